// File: doc/BRIEF.md
# Stack-Addressed Tagged Register File

This block holds eight 80-bit floating-point values whose addresses rotate with a 3-bit top pointer. Stack slot `k` is the physical entry `(top + k) mod 8`. Each entry carries a 2-bit tag. The stack operations are push, pop, exchange, probe and mark-all-empty. They move the pointer and keep the tags up to date. The block raises a one-cycle overflow flag when a push hits an occupied entry. It raises a one-cycle underflow flag when an operation touches an empty entry.

The same storage can also be used as eight directly indexed 64-bit packed-integer registers, through a second port. A write on that port hands the whole file over to packed use: the pointer returns to 0 and every tag becomes valid. The mark-all-empty operation gives the file back to floating-point use. The pointer is brought out so that a status word can carry it.

Top module: `stack_regfile`

## Requirements
- R1: After reset the top pointer is 0, all eight tags are 11 (empty), every entry reads zero, and both flags are 0.
- R2: Operation code 1 (push) computes `n = top-1 mod 8`. When tag `n` is 11, it writes the data to entry `n` and sets `top = n`. The new tag is 10 (special) if the special input is high. Otherwise it is 01 (zero) if data bits 78:0 are all zero, and 00 (valid) in every other case.
- R3: A push whose target entry `n` is not empty raises `ovf` for one cycle, in the cycle after the operation. Pointer, tags and data are left unchanged.
- R4: Operation code 2 (pop) on a non-empty stack slot 0 sets that entry's tag to 11 and then increments the top pointer modulo 8.
- R5: A pop of an empty slot 0 raises `unf` for one cycle and changes nothing. So does operation code 4 (probe) of an empty stack slot `idx`.
- R6: Operation code 3 (exchange) swaps stack slot 0 and stack slot `idx`, data and tags together, in one cycle. If either slot is empty, it raises `unf` and changes nothing.
- R7: `rd_data`/`rd_tag` show stack slot `rd_idx` combinationally, that is physical entry `(top + rd_idx) mod 8`.
- R8: `mm_rdata` shows bits 63:0 of physical entry `mm_idx` combinationally.
- R9: A packed write (`mm_wr_en` high) stores `mm_wdata` in bits 63:0 of entry `mm_widx` and sets bits 79:64 of that entry to all ones. It sets every tag to 00 and the pointer to 0. The stack operation in the same cycle is ignored.
- R10: Operation code 5 (mark-all-empty) sets all tags to 11. Data and pointer are unchanged.
- R11: Operation codes 0, 6 and 7 change no state and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Stack operation code |
| idx | input | 3 | Stack slot for exchange and probe |
| push_data | input | 80 | Value to push |
| push_special | input | 1 | Tag the pushed value as special |
| rd_idx | input | 3 | Stack slot shown on the read port |
| rd_data | output | 80 | Value in stack slot `rd_idx` |
| rd_tag | output | 2 | Tag of stack slot `rd_idx` |
| mm_wr_en | input | 1 | Packed-mode write enable |
| mm_widx | input | 3 | Physical entry for the packed write |
| mm_wdata | input | 64 | Packed write data |
| mm_idx | input | 3 | Physical entry for the packed read |
| mm_rdata | output | 64 | Low 64 bits of entry `mm_idx` |
| top_o | output | 3 | Top-of-stack pointer |
| tags_o | output | 16 | All tags, entry `e` at bits `2e+1:2e` |
| ovf | output | 1 | Stack overflow pulse |
| unf | output | 1 | Stack underflow pulse |

## Verification
The pointer and every tag are visible at the ports at all times. A wrong pointer update or a wrong tag therefore shows on `top_o` or `tags_o` at the first sample after the faulty edge. A data word that is swapped or written into the wrong entry is caught as soon as the read ports address it. Both ports are re-sampled at random slot numbers after every operation, so this usually happens within a few operations. A wrong flag decision shows one cycle after the operation that caused it.

// File: rtl/stack_regfile.sv
module stack_regfile #(
  parameter int W  = 80,
  parameter int N  = 8,
  parameter int MW = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op,
  input  logic [$clog2(N)-1:0] idx,
  input  logic [W-1:0]         push_data,
  input  logic                 push_special,
  input  logic [$clog2(N)-1:0] rd_idx,
  output logic [W-1:0]         rd_data,
  output logic [1:0]           rd_tag,
  input  logic                 mm_wr_en,
  input  logic [$clog2(N)-1:0] mm_widx,
  input  logic [MW-1:0]        mm_wdata,
  input  logic [$clog2(N)-1:0] mm_idx,
  output logic [MW-1:0]        mm_rdata,
  output logic [$clog2(N)-1:0] top_o,
  output logic [2*N-1:0]       tags_o,
  output logic                 ovf,
  output logic                 unf
);
  localparam int AW = $clog2(N);
  localparam logic [1:0] T_VALID = 2'b00, T_ZERO = 2'b01, T_SPEC = 2'b10, T_EMPTY = 2'b11;
  localparam logic [2:0] OP_PUSH = 3'd1, OP_POP = 3'd2, OP_XCHG = 3'd3, OP_PROBE = 3'd4, OP_CLR = 3'd5;

  logic [W-1:0]  mem [N];
  logic [1:0]    tag [N];
  logic [AW-1:0] top;

  wire [AW-1:0] dn    = top - 1'b1;
  wire [AW-1:0] up    = top + 1'b1;
  wire [AW-1:0] slot  = top + idx;
  wire [AW-1:0] rslot = top + rd_idx;
  wire [1:0] push_tag = push_special ? T_SPEC :
                        (push_data[W-2:0] == '0) ? T_ZERO : T_VALID;

  assign rd_data  = mem[rslot];
  assign rd_tag   = tag[rslot];
  assign mm_rdata = mem[mm_idx][MW-1:0];
  assign top_o    = top;

  for (genvar e = 0; e < N; e++) begin : g_tags
    assign tags_o[2*e +: 2] = tag[e];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
      for (int e = 0; e < N; e++) begin
        mem[e] <= '0;
        tag[e] <= T_EMPTY;
      end
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (mm_wr_en) begin
        mem[mm_widx] <= {{(W-MW){1'b1}}, mm_wdata};
        top <= '0;
        for (int e = 0; e < N; e++) tag[e] <= T_VALID;
      end else begin
        case (op)
          OP_PUSH:
            if (tag[dn] != T_EMPTY) ovf <= 1'b1;
            else begin
              mem[dn] <= push_data;
              tag[dn] <= push_tag;
              top     <= dn;
            end
          OP_POP:
            if (tag[top] == T_EMPTY) unf <= 1'b1;
            else begin
              tag[top] <= T_EMPTY;
              top      <= up;
            end
          OP_XCHG:
            if (tag[top] == T_EMPTY || tag[slot] == T_EMPTY) unf <= 1'b1;
            else begin
              mem[top]  <= mem[slot];
              mem[slot] <= mem[top];
              tag[top]  <= tag[slot];
              tag[slot] <= tag[top];
            end
          OP_PROBE:
            if (tag[slot] == T_EMPTY) unf <= 1'b1;
          OP_CLR:
            for (int e = 0; e < N; e++) tag[e] <= T_EMPTY;
          default: ;
        endcase
      end
    end
  end
endmodule

module stack_regfile_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           op,
  input logic                 mm_wr_en,
  input logic [$clog2(N)-1:0] top_o,
  input logic [2*N-1:0]       tags_o,
  input logic                 ovf,
  input logic                 unf
);
  // R3
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $stable(top_o) && $stable(tags_o));
  // R5
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> $stable(top_o) && $stable(tags_o));
  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf, unf}));
  // R9
  mm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mm_wr_en |=> top_o == '0 && tags_o == '0);
  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mm_wr_en && op == 3'd5) |=> tags_o == '1 && $stable(top_o));
  // R4
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mm_wr_en && op == 3'd2) |=> unf || top_o == $past(top_o) + 1'b1);
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mm_wr_en && (op == 3'd0 || op == 3'd6 || op == 3'd7)) |=>
      $stable(top_o) && $stable(tags_o) && !ovf && !unf);
endmodule

bind stack_regfile stack_regfile_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .mm_wr_en(mm_wr_en),
  .top_o(top_o), .tags_o(tags_o), .ovf(ovf), .unf(unf)
);

// File: tb/stack_regfile_tb.sv
module stack_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] op = 0, idx = 0, rd_idx = 0, mm_widx = 0, mm_idx = 0;
  logic [79:0] push_data = 0;
  logic push_special = 0, mm_wr_en = 0;
  logic [63:0] mm_wdata = 0;
  logic [79:0] rd_data;
  logic [1:0] rd_tag;
  logic [63:0] mm_rdata;
  logic [2:0] top_o;
  logic [15:0] tags_o;
  logic ovf, unf;

  int checks = 0, failures = 0;
  logic [79:0] m_mem [8];
  logic [1:0]  m_tag [8];
  logic [2:0]  m_top;
  logic e_ovf, e_unf;

  always #4 clk = ~clk;

  stack_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(idx), .push_data(push_data),
    .push_special(push_special), .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag),
    .mm_wr_en(mm_wr_en), .mm_widx(mm_widx), .mm_wdata(mm_wdata), .mm_idx(mm_idx),
    .mm_rdata(mm_rdata), .top_o(top_o), .tags_o(tags_o), .ovf(ovf), .unf(unf)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_tags();
    logic [15:0] t;
    for (int e = 0; e < 8; e++) t[2*e +: 2] = m_tag[e];
    return t;
  endfunction

  function automatic logic [1:0] tag_of(input logic [79:0] d, input logic s);
    return s ? 2'b10 : (d[78:0] == 0) ? 2'b01 : 2'b00;
  endfunction

  task automatic model();
    logic [2:0] n, a, b;
    logic [79:0] td;
    logic [1:0] tt;
    e_ovf = 0; e_unf = 0;
    if (mm_wr_en) begin
      m_mem[mm_widx] = {16'hFFFF, mm_wdata};
      for (int e = 0; e < 8; e++) m_tag[e] = 2'b00;
      m_top = 0;
    end else case (op)
      3'd1: begin
        n = m_top - 3'd1;
        if (m_tag[n] != 2'b11) e_ovf = 1;
        else begin m_mem[n] = push_data; m_tag[n] = tag_of(push_data, push_special); m_top = n; end
      end
      3'd2: if (m_tag[m_top] == 2'b11) e_unf = 1;
            else begin m_tag[m_top] = 2'b11; m_top = m_top + 3'd1; end
      3'd3: begin
        a = m_top; b = m_top + idx;
        if (m_tag[a] == 2'b11 || m_tag[b] == 2'b11) e_unf = 1;
        else begin
          td = m_mem[a]; m_mem[a] = m_mem[b]; m_mem[b] = td;
          tt = m_tag[a]; m_tag[a] = m_tag[b]; m_tag[b] = tt;
        end
      end
      3'd4: if (m_tag[3'(m_top + idx)] == 2'b11) e_unf = 1;
      3'd5: for (int e = 0; e < 8; e++) m_tag[e] = 2'b11;
      default: ;
    endcase
  endtask

  function automatic string req_of();
    if (mm_wr_en) return "R9";
    case (op)
      3'd1: return "R2/R3";
      3'd2: return "R4/R5";
      3'd3: return "R6";
      3'd4: return "R5";
      3'd5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(input string r);
    logic [2:0] rs;
    rs = m_top + rd_idx;
    chk(top_o == m_top, {r, " top"}, 80'(top_o), 80'(m_top));
    chk(tags_o == m_tags(), {r, " tags"}, 80'(tags_o), 80'(m_tags()));
    chk(ovf == e_ovf, {r, " ovf R3"}, 80'(ovf), 80'(e_ovf));
    chk(unf == e_unf, {r, " unf R5"}, 80'(unf), 80'(e_unf));
    chk(rd_data == m_mem[rs] && rd_tag == m_tag[rs], {r, " R7 read port"}, rd_data, m_mem[rs]);
    chk(mm_rdata == m_mem[mm_idx][63:0], {r, " R8 packed read"}, 80'(mm_rdata), 80'(m_mem[mm_idx][63:0]));
  endtask

  task automatic step(input logic [2:0] o, input logic [2:0] i, input logic [79:0] d,
                      input logic s, input logic mw, input logic [2:0] mwi, input logic [63:0] md);
    string r;
    op = o; idx = i; push_data = d; push_special = s;
    mm_wr_en = mw; mm_widx = mwi; mm_wdata = md;
    rd_idx = 3'($urandom); mm_idx = 3'($urandom);
    r = req_of();
    model();
    @(posedge clk); @(negedge clk);
    compare(r);
  endtask

  function automatic logic [79:0] rnd80();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog act=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < 8; e++) begin m_mem[e] = 0; m_tag[e] = 2'b11; end
    m_top = 0; e_ovf = 0; e_unf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");
    // R5: pop on empty
    step(3'd2, 0, 0, 0, 0, 0, 0);
    // R2: fill with pushes including zero and special tags; R3: ninth push overflows
    step(3'd1, 0, 80'h0, 0, 0, 0, 0);
    step(3'd1, 0, 80'h8000_0000_0000_0000_0000, 0, 0, 0, 0);
    step(3'd1, 0, rnd80(), 1, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(3'd1, 0, rnd80(), 0, 0, 0, 0);
    step(3'd1, 0, rnd80(), 0, 0, 0, 0);
    // R6: exchanges at several distances
    for (int k = 0; k < 8; k++) step(3'd3, 3'(k), 0, 0, 0, 0, 0);
    // R11: idle codes
    step(3'd6, 0, rnd80(), 0, 0, 0, 0);
    step(3'd7, 0, rnd80(), 0, 0, 0, 0);
    // R4: pop everything, then R5 again
    for (int k = 0; k < 9; k++) step(3'd2, 0, 0, 0, 0, 0, 0);
    // R9 then R10
    step(3'd1, 0, rnd80(), 0, 1, 3'd5, 64'hDEAD_BEEF_0123_4567);
    step(3'd5, 0, 0, 0, 0, 0, 0);
    step(3'd4, 3'd2, 0, 0, 0, 0, 0);
    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] o;
      logic mw;
      o = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) o = 3'd1;
      if ($urandom_range(0, 5) == 0) o = 3'd2;
      mw = ($urandom_range(0, 31) == 0);
      step(o, 3'($urandom), ($urandom_range(0, 7) == 0) ? 80'h0 : rnd80(),
           ($urandom_range(0, 5) == 0), mw, 3'($urandom), {$urandom, $urandom});
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule